// File: doc/BRIEF.md
# Operand Effective Address Generator

The block turns one decoded operand specifier into the byte address that the operand fetch stage will use. A caller presents a 3-bit addressing-mode code, a register index, a 16-bit instruction field, the program counter (already advanced past the current instruction), the operand size and a destination flag, and pulses `start_i`. The unit reads the register file through a combinational port. For memory-indirect specifiers it issues one read on a valid/ready memory port. It then reports the address together with an immediate flag, a misalignment flag and an error flag for one cycle.

The auto-modify modes change a pointer register. Post-increment addresses through the old register value. Pre-decrement addresses through the new value. The step in both cases is the operand size in bytes. The unit writes the new pointer back in the same cycle that it reports the result. In immediate mode the field itself is the operand, so no address is formed.

Top module: `ea_unit`

## Requirements
- R1: After reset `done_o`, `busy_o`, `rf_we_o` and `mem_valid_o` are low.
- R2: A start is accepted on a rising edge where `start_i` is high and `busy_o` is low. For every mode except memory-indirect (code 2), `done_o` is high for exactly the one cycle after the accepting edge.
- R3: Immediate mode (code 0) gives `imm_o`=1 and an `addr_o` equal to the sign-extended field. It gives no register write and `misalign_o`=0.
- R4: Register-indirect mode (code 1) gives `addr_o` equal to the named register.
- R5: Indexed mode (code 3) gives the sign-extended field plus the named register.
- R6: Post-increment mode (code 4) gives the register's old value as `addr_o`. In the same cycle as `done_o` it writes the register with the old value plus the step size.
- R7: Pre-decrement mode (code 5) gives the register minus the step size as `addr_o`, and writes that same value back in the same cycle as `done_o`.
- R8: PC-relative mode (code 6) gives `pc_i` plus the sign-extended field.
- R9: Memory-indirect mode (code 2) raises `mem_valid_o` with `mem_addr_o` equal to the zero-extended field. It holds that address until `mem_ready_i`. `done_o` then follows in the next cycle, with `addr_o` equal to the `mem_rdata_i` value taken at the handshake.
- R10: The size code is the log2 of the byte count (0..3 gives 1, 2, 4 or 8 bytes). `misalign_o` is 1 exactly when `addr_o` mod the byte count is not 0. The step in R6 and R7 is the byte count.
- R11: Code 7, and immediate mode with `dst_i`=1, give `err_o`=1 with `done_o`. They give no register write, no memory read, and an `addr_o` and `misalign_o` of 0.
- R12: A `start_i` pulse while `busy_o` is high is ignored: it produces no extra result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin one address computation |
| mode_i | input | 3 | Addressing-mode code |
| reg_idx_i | input | 4 | Register index |
| field_i | input | 16 | Immediate, index, offset or pointer location |
| pc_i | input | 32 | Program counter after the current instruction |
| size_i | input | 2 | Operand size, log2 of bytes |
| dst_i | input | 1 | Operand is a destination |
| busy_o | output | 1 | Unit is occupied; start is ignored |
| rf_raddr_o | output | 4 | Register file read index |
| rf_rdata_i | input | 32 | Register file read data (combinational) |
| rf_we_o | output | 1 | Pointer write-back enable |
| rf_waddr_o | output | 4 | Pointer write-back index |
| rf_wdata_o | output | 32 | Pointer write-back value |
| mem_valid_o | output | 1 | Pointer read request |
| mem_addr_o | output | 32 | Pointer read address |
| mem_ready_i | input | 1 | Read accepted; data valid this cycle |
| mem_rdata_i | input | 32 | Read data |
| done_o | output | 1 | Result valid, one cycle |
| addr_o | output | 32 | Effective address, or the immediate value |
| imm_o | output | 1 | Result is an immediate operand |
| misalign_o | output | 1 | Address is not a multiple of the size |
| err_o | output | 1 | Illegal specifier |

## Verification
The hardest case to reach is a second start that arrives while a memory-indirect read is still waiting on `mem_ready_i`. The bench holds the memory model's ready low for several cycles and pulses a fresh start in that window. It then checks that the result count and the register file match the single accepted request. Chained post-increment and pre-decrement operations on one register check the write-back timing: each later address depends on the value written back by the one before.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [2:0] {
    MODE_IMM   = 3'd0,
    MODE_RIND  = 3'd1,
    MODE_MIND  = 3'd2,
    MODE_IDX   = 3'd3,
    MODE_AINC  = 3'd4,
    MODE_ADEC  = 3'd5,
    MODE_PCREL = 3'd6,
    MODE_BAD   = 3'd7
  } ea_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEM  = 2'd1,
    ST_DONE = 2'd2
  } ea_state_e;
endpackage

// File: rtl/ea_calc.sv
module ea_calc
  import ea_pkg::*;
#(
  parameter int AW = 32,
  parameter int FW = 16
) (
  input  ea_mode_e        mode_i,
  input  logic [FW-1:0]   field_i,
  input  logic [AW-1:0]   pc_i,
  input  logic [AW-1:0]   reg_i,
  input  logic [1:0]      size_i,
  input  logic            dst_i,
  output logic [AW-1:0]   addr_o,
  output logic            imm_o,
  output logic            err_o,
  output logic            wb_en_o,
  output logic [AW-1:0]   wb_val_o
);
  logic [AW-1:0] sext, step, dec;

  assign sext = {{(AW-FW){field_i[FW-1]}}, field_i};
  assign step = {{(AW-1){1'b0}}, 1'b1} << size_i;
  assign dec  = reg_i - step;

  always_comb begin
    addr_o   = '0;
    imm_o    = 1'b0;
    err_o    = 1'b0;
    wb_en_o  = 1'b0;
    wb_val_o = '0;
    unique case (mode_i)
      MODE_IMM: begin
        if (dst_i) err_o = 1'b1;
        else begin
          imm_o  = 1'b1;
          addr_o = sext;
        end
      end
      MODE_RIND:  addr_o = reg_i;
      MODE_MIND:  addr_o = {{(AW-FW){1'b0}}, field_i};
      MODE_IDX:   addr_o = sext + reg_i;
      MODE_AINC: begin
        addr_o   = reg_i;
        wb_en_o  = 1'b1;
        wb_val_o = reg_i + step;
      end
      MODE_ADEC: begin
        addr_o   = dec;
        wb_en_o  = 1'b1;
        wb_val_o = dec;
      end
      MODE_PCREL: addr_o = pc_i + sext;
      default:    err_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/ea_align.sv
module ea_align #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  output logic          misalign_o
);
  logic [3:0] low_mask;

  always_comb begin
    unique case (size_i)
      2'd0:    low_mask = 4'b0000;
      2'd1:    low_mask = 4'b0001;
      2'd2:    low_mask = 4'b0011;
      default: low_mask = 4'b0111;
    endcase
  end

  assign misalign_o = |(addr_i[3:0] & low_mask);
endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter int AW   = 32,
  parameter int FW   = 16,
  parameter int NREG = 16,
  localparam int RIW = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [2:0]      mode_i,
  input  logic [RIW-1:0]  reg_idx_i,
  input  logic [FW-1:0]   field_i,
  input  logic [AW-1:0]   pc_i,
  input  logic [1:0]      size_i,
  input  logic            dst_i,
  output logic            busy_o,
  output logic [RIW-1:0]  rf_raddr_o,
  input  logic [AW-1:0]   rf_rdata_i,
  output logic            rf_we_o,
  output logic [RIW-1:0]  rf_waddr_o,
  output logic [AW-1:0]   rf_wdata_o,
  output logic            mem_valid_o,
  output logic [AW-1:0]   mem_addr_o,
  input  logic            mem_ready_i,
  input  logic [AW-1:0]   mem_rdata_i,
  output logic            done_o,
  output logic [AW-1:0]   addr_o,
  output logic            imm_o,
  output logic            misalign_o,
  output logic            err_o
);
  ea_state_e       state_q;
  logic [AW-1:0]   addr_q, wb_val_q;
  logic [RIW-1:0]  wb_idx_q;
  logic [1:0]      size_q;
  logic            imm_q, err_q, wb_en_q;
  logic            accept;
  logic [AW-1:0]   c_addr, c_wb_val;
  logic            c_imm, c_err, c_wb_en, mis_raw;

  assign accept     = start_i && (state_q == ST_IDLE);
  assign rf_raddr_o = reg_idx_i;

  ea_calc #(.AW(AW), .FW(FW)) u_calc (
    .mode_i   (ea_mode_e'(mode_i)),
    .field_i  (field_i),
    .pc_i     (pc_i),
    .reg_i    (rf_rdata_i),
    .size_i   (size_i),
    .dst_i    (dst_i),
    .addr_o   (c_addr),
    .imm_o    (c_imm),
    .err_o    (c_err),
    .wb_en_o  (c_wb_en),
    .wb_val_o (c_wb_val)
  );

  ea_align #(.AW(AW)) u_align (
    .addr_i     (addr_q),
    .size_i     (size_q),
    .misalign_o (mis_raw)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      wb_val_q <= '0;
      wb_idx_q <= '0;
      size_q   <= '0;
      imm_q    <= 1'b0;
      err_q    <= 1'b0;
      wb_en_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          addr_q   <= c_addr;
          imm_q    <= c_imm;
          err_q    <= c_err;
          wb_en_q  <= c_wb_en;
          wb_val_q <= c_wb_val;
          wb_idx_q <= reg_idx_i;
          size_q   <= size_i;
          state_q  <= (mode_i == MODE_MIND) ? ST_MEM : ST_DONE;
        end
        ST_MEM: if (mem_ready_i) begin
          addr_q  <= mem_rdata_i;
          state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign addr_o      = addr_q;
  assign imm_o       = done_o && imm_q;
  assign err_o       = done_o && err_q;
  assign misalign_o  = done_o && !imm_q && !err_q && mis_raw;
  assign rf_we_o     = done_o && wb_en_q;
  assign rf_waddr_o  = wb_idx_q;
  assign rf_wdata_o  = wb_val_q;
  assign mem_valid_o = (state_q == ST_MEM);
  assign mem_addr_o  = addr_q;

  // R2
  one_cycle_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && (mode_i != MODE_MIND) |=> done_o);
  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o));
  // R9
  mem_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && mem_ready_i |=> done_o && addr_o == $past(mem_rdata_i));
  // R6
  wb_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> done_o);
  // R11
  err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !rf_we_o && !misalign_o && !mem_valid_o);
  // R3
  imm_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imm_o |-> !rf_we_o && !misalign_o);
endmodule

// File: tb/sim_ea_unit.sv
module sim_ea_unit;
  localparam int AW = 32;
  localparam int FW = 16;

  typedef struct {
    logic [AW-1:0] addr;
    logic          imm, mis, err, we;
    logic [3:0]    widx;
    logic [AW-1:0] wdata;
    logic [8*3-1:0] req;
  } exp_t;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic          start = 0, dst = 0, mem_ready = 0;
  logic [2:0]    mode = 0;
  logic [3:0]    ridx = 0;
  logic [FW-1:0] field = 0;
  logic [AW-1:0] pc = 0;
  logic [1:0]    size = 0;
  logic          busy, rf_we, mem_valid, done, imm, mis, err;
  logic [3:0]    rf_raddr, rf_waddr;
  logic [AW-1:0] rf_rdata, rf_wdata, mem_addr, mem_rdata, addr;

  logic [AW-1:0] rf [16];
  assign rf_rdata  = rf[rf_raddr];
  assign mem_rdata = {mem_addr[AW-5:0], 4'h6} ^ 32'h5A00_0000;

  ea_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .reg_idx_i(ridx), .field_i(field), .pc_i(pc), .size_i(size), .dst_i(dst),
    .busy_o(busy), .rf_raddr_o(rf_raddr), .rf_rdata_i(rf_rdata),
    .rf_we_o(rf_we), .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata),
    .mem_valid_o(mem_valid), .mem_addr_o(mem_addr), .mem_ready_i(mem_ready),
    .mem_rdata_i(mem_rdata), .done_o(done), .addr_o(addr), .imm_o(imm),
    .misalign_o(mis), .err_o(err)
  );

  int checks = 0, fails = 0, issued = 0, seen = 0;
  exp_t q[$];
  int mem_delay = 0, mcnt = 0;
  logic exp_mem_on = 0;
  logic [AW-1:0] exp_mem_addr = 0;
  bit finished = 0;

  always @(posedge clk) if (rf_we) rf[rf_waddr] <= rf_wdata;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model and request checks
  always @(negedge clk) begin
    if (mem_valid) begin
      chk(exp_mem_on, "R11", "unexpected read", 1, 0);
      chk(mem_addr == exp_mem_addr, "R9", "read addr", mem_addr, exp_mem_addr);
      mem_ready = (mcnt >= mem_delay);
      mcnt++;
    end else begin
      mem_ready = 0;
      mcnt = 0;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      seen++;
      if (q.size() == 0) chk(0, "R12", "extra result", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(addr == e.addr, e.req, "addr", addr, e.addr);
        chk(imm == e.imm && err == e.err, e.req, "imm/err",
            {imm, err}, {e.imm, e.err});
        chk(mis == e.mis, "R10", "misalign", mis, e.mis);
        chk(rf_we == e.we, e.req, "wb enable", rf_we, e.we);
        if (e.we) chk(rf_waddr == e.widx && rf_wdata == e.wdata, e.req,
                      "wb data", rf_wdata, e.wdata);
      end
      exp_mem_on = 0;
    end
  end

  function automatic logic [AW-1:0] sx(input logic [FW-1:0] f);
    return {{(AW-FW){f[FW-1]}}, f};
  endfunction

  task automatic issue(input logic [2:0] m, input logic [3:0] r,
                       input logic [FW-1:0] f, input logic [1:0] s,
                       input logic d, input logic [AW-1:0] p,
                       input logic [8*3-1:0] req, input int dly, input bit poke);
    exp_t e;
    logic [AW-1:0] stp, rv;
    @(negedge clk);
    while (busy) @(negedge clk);
    stp = 32'd1 << s;
    rv  = rf[r];
    e.imm = 0; e.err = 0; e.we = 0; e.widx = r; e.wdata = 0; e.addr = 0;
    e.req = req;
    case (m)
      3'd0: if (d) e.err = 1; else begin e.imm = 1; e.addr = sx(f); end
      3'd1: e.addr = rv;
      3'd2: e.addr = {mem_addr_x(f)[AW-5:0], 4'h6} ^ 32'h5A00_0000;
      3'd3: e.addr = sx(f) + rv;
      3'd4: begin e.addr = rv; e.we = 1; e.wdata = rv + stp; end
      3'd5: begin e.addr = rv - stp; e.we = 1; e.wdata = rv - stp; end
      3'd6: e.addr = p + sx(f);
      default: e.err = 1;
    endcase
    e.mis = (!e.imm && !e.err) && ((e.addr & (stp - 1)) != 0);
    q.push_back(e);
    issued++;
    mode = m; ridx = r; field = f; size = s; dst = d; pc = p;
    mem_delay = dly;
    exp_mem_addr = mem_addr_x(f);
    exp_mem_on = (m == 3'd2);
    start = 1;
    @(negedge clk);
    start = 0;
    if (poke) begin
      mode = 3'd1; ridx = 4'd7; start = 1;
      @(negedge clk);
      start = 0;
    end
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  function automatic logic [AW-1:0] mem_addr_x(input logic [FW-1:0] f);
    return {{(AW-FW){1'b0}}, f};
  endfunction

  initial begin
    for (int i = 0; i < 16; i++) rf[i] = 32'h1000 + 32'(i) * 32'h10;
    rf[3] = 32'h0000_2003;
    #1;
    chk(!done && !busy && !rf_we && !mem_valid, "R1", "reset outputs",
        {done, busy, rf_we, mem_valid}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    chk(!done && !busy, "R1", "after release", {done, busy}, 0);

    issue(3'd0, 4'd0, 16'hFFF0, 2'd2, 0, 0, "R3", 0, 0);
    issue(3'd0, 4'd0, 16'h0010, 2'd0, 1, 0, "R11", 0, 0);
    issue(3'd1, 4'd3, 16'h0000, 2'd0, 0, 0, "R4", 0, 0);
    issue(3'd1, 4'd3, 16'h0000, 2'd2, 0, 0, "R10", 0, 0);
    issue(3'd3, 4'd1, 16'hFFF8, 2'd3, 0, 0, "R5", 0, 0);
    issue(3'd4, 4'd2, 16'h0000, 2'd2, 0, 0, "R6", 0, 0);
    issue(3'd4, 4'd2, 16'h0000, 2'd3, 0, 0, "R6", 0, 0);
    issue(3'd5, 4'd5, 16'h0000, 2'd1, 0, 0, "R7", 0, 0);
    issue(3'd5, 4'd5, 16'h0000, 2'd0, 0, 0, "R7", 0, 0);
    issue(3'd6, 4'd0, 16'h8000, 2'd0, 0, 32'h0001_0400, "R8", 0, 0);
    issue(3'd6, 4'd0, 16'h0022, 2'd2, 0, 32'h0000_0400, "R8", 0, 0);
    issue(3'd2, 4'd0, 16'h0123, 2'd1, 0, 0, "R9", 0, 0);
    issue(3'd2, 4'd0, 16'h8844, 2'd2, 1, 0, "R9", 4, 1);
    issue(3'd7, 4'd4, 16'h1234, 2'd0, 0, 0, "R11", 0, 0);
    issue(3'd4, 4'd7, 16'h0000, 2'd0, 0, 0, "R12", 0, 0);
    // R2: timing of a plain request
    @(negedge clk);
    mode = 3'd1; ridx = 4'd3; start = 1;
    @(negedge clk);
    start = 0;
    chk(done, "R2", "done one cycle after accept", done, 1);
    q.push_back('{addr: rf[3], imm: 0, mis: 1'b1 & 0, err: 0, we: 0,
                  widx: 3, wdata: 0, req: "R2"});
    issued++;
    @(negedge clk);
    chk(!done, "R2", "single pulse", done, 0);
    repeat (3) @(negedge clk);
    chk(seen == issued, "R12", "result count", seen, issued);
    chk(rf[7] == 32'h1070 + 1, "R12", "reg after busy start", rf[7], 32'h1071);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule